// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master that moves one byte at a time. Software reaches it through a small byte-addressed register bus. It sets the clock polarity, clock phase and bit order, and it sets a two-field clock divider. Writing a byte to the data register then starts a full-duplex 8-bit exchange. The byte received from the slave is read back at the same address. Completion raises a status flag and, when enabled, an interrupt line.

The block guards against two common misuses. A data write that lands while a byte is still shifting raises a collision flag and is dropped. A slave-select input pulled low while the block acts as master raises a mode-fault flag, stops the shift at once and drives a second interrupt line.

Slave select is driven from a port data/direction register pair. Each flag clears through a fixed sequence of register accesses, so a flag cannot be lost to a stray access.

Top module: `spi_byte_master`

## Requirements
- R1: The registers sit at these bus addresses: control 0x00, spare control 0x01, divider 0x04, status 0x05, data 0x09, pin level 0x0D and pin direction 0x10. Each one except status reads back what was written. The divider keeps only bits 6:4 and 2:0. Any other address reads 0x00. After reset every register reads 0x00.
- R2: The control bits are: bit 7 interrupt enable, bit 6 block enable, bit 4 master, bit 3 polarity, bit 2 phase, bit 0 LSB first. With bits 6 and 4 both set and no shift running, a write to address 0x09 starts an 8-bit full-duplex exchange. The received byte is then read from address 0x09.
- R3: SCK idles at the polarity bit. With phase 0 the first bit is sampled on the leading SCK edge; with phase 1 it is sampled on the trailing edge. Bit 0 of the control register selects LSB-first order for both directions.
- R4: The divider holds a prescaler p in bits 6:4 and an exponent e in bits 2:0. Each SCK half period lasts (p+1)·2^e bus clocks. The completion flag sets 16·(p+1)·2^e + 1 clocks after the clock edge that accepts the data write.
- R5: In the status register, bit 7 means transfer complete, bit 6 means write collision and bit 4 means mode fault. All other bits read 0.
- R6: The complete and collision flags clear on a data-register read or write that follows a status read which saw either flag set. A data access with no such status read first leaves both flags set.
- R7: A data write made while a shift runs sets the collision flag. The written byte is dropped, and the running exchange finishes with its original byte.
- R8: A mode fault occurs when the block is enabled, in master mode, with pin-direction bit 3 at 0, and the slave-select input is low after a two-stage synchronizer. The fault sets the mode-fault flag and aborts any shift. The flag clears on a control write that follows a status read which saw it set; a control write with no such status read first leaves it set.
- R9: While the enable bit is 0, all flags read 0, SCK rests at its idle level and data writes start nothing. Data writes with the master bit at 0 also start nothing.
- R10: The complete interrupt equals enable AND complete flag, and the fault interrupt equals enable AND mode-fault flag. Each one is registered, so it follows its flag by one clock.
- R11: When pin-direction bit 3 is 1, the slave-select output takes the value of pin-level bit 3 and the output-enable pin is 1. When direction bit 3 is 0, the select output is high and the output-enable pin is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_in_n | input | 1 | Slave-select input used for mode-fault detection |
| ss_n_o | output | 1 | Slave-select output, active low |
| ss_oe | output | 1 | Output enable for the slave-select pin |
| irq_done | output | 1 | Transfer-complete interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |

## Verification
Several properties are checked on every cycle: SCK rests at the polarity level whenever no shift runs, a busy data write always leads to the collision flag, a fault condition always sets the fault flag and stops the shifter, disabling the block clears every flag, completion always raises the complete flag, and both interrupt lines track their flags. Only the bench scenarios can show the rest. These are the byte values exchanged in each mode and bit order, the exact clock count set by the divider, the access sequences that do or do not clear a flag, and the fact that a dropped byte never reaches the wire.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  // register addresses
  localparam int A_CTRL  = 'h00;
  localparam int A_CTRL2 = 'h01;
  localparam int A_DIV   = 'h04;
  localparam int A_STAT  = 'h05;
  localparam int A_DATA  = 'h09;
  localparam int A_PLVL  = 'h0D;
  localparam int A_PDIR  = 'h10;
  // control bit positions
  localparam int C_IE  = 7;
  localparam int C_EN  = 6;
  localparam int C_MST = 4;
  localparam int C_POL = 3;
  localparam int C_PHA = 2;
  localparam int C_LSB = 0;
  // status bit positions
  localparam int S_DONE = 7;
  localparam int S_COL  = 6;
  localparam int S_FLT  = 4;
  // divider fields
  localparam int PRE_W  = 3;
  localparam int PRE_LO = 4;
  localparam int EXP_W  = 3;
  localparam int EXP_LO = 0;
  localparam logic [7:0] DIV_MASK = 8'h77;
  // pin register bit for slave select
  localparam int PIN_SS = 3;
endpackage

// File: rtl/sbm_baud.sv
module sbm_baud #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;

  // half period = (pre + 1) << expo bus clocks
  assign half = CNT_W'({1'b0, pre} + 1'b1) << expo;
  assign tick = en && (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbm_shift.sv
module sbm_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic         tick,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsbf,
  input  logic         miso,
  input  logic [W-1:0] tx,
  output logic         busy,
  output logic         done,
  output logic         sck,
  output logic         mosi,
  output logic [W-1:0] sr
);
  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] LAST = CW'(2 * W - 1);

  logic [CW-1:0] edg;
  logic          smp;

  // even edge index = leading edge; phase picks which edge samples
  assign smp = cpha ? edg[0] : ~edg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      sr   <= '0;
      edg  <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        sck  <= cpol;
      end else if (!busy) begin
        sck <= cpol;
        if (start) begin
          busy <= 1'b1;
          edg  <= '0;
          sr   <= tx;
          mosi <= lsbf ? tx[0] : tx[W-1];
        end
      end else if (tick) begin
        sck <= ~sck;
        edg <= edg + 1'b1;
        if (smp) sr <= lsbf ? {miso, sr[W-1:1]} : {sr[W-2:0], miso};
        else     mosi <= lsbf ? sr[0] : sr[W-1];
        if (edg == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import sbm_pkg::*;
#(
  parameter int AW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  input  logic          ss_in_n,
  output logic          ss_n_o,
  output logic          ss_oe,
  output logic          irq_done,
  output logic          irq_fault
);
  logic [7:0] ctl_q, ctl2_q, div_q, plvl_q, pdir_q, rx_q, stat_byte;
  logic       spif_q, wcol_q, modf_q, arm_x_q, arm_m_q;
  logic [SYNC_STAGES-1:0] ss_pipe;
  logic spe, mstr, cpol, cpha, lsbf, spie;
  logic hit_ctl, hit_data, hit_stat;
  logic status_rd, data_wr, data_acc, ctl_wr, fault, start, abort;
  logic tick, busy, done;
  logic [7:0] sr_out;

  assign spe  = ctl_q[C_EN];
  assign mstr = ctl_q[C_MST];
  assign cpol = ctl_q[C_POL];
  assign cpha = ctl_q[C_PHA];
  assign lsbf = ctl_q[C_LSB];
  assign spie = ctl_q[C_IE];

  assign hit_ctl   = bus_addr == AW'(A_CTRL);
  assign hit_data  = bus_addr == AW'(A_DATA);
  assign hit_stat  = bus_addr == AW'(A_STAT);
  assign status_rd = bus_rd && hit_stat;
  assign data_wr   = bus_wr && hit_data;
  assign data_acc  = (bus_rd || bus_wr) && hit_data;
  assign ctl_wr    = bus_wr && hit_ctl;

  // slave-select input synchronizer
  always_ff @(posedge clk) begin
    if (rst) ss_pipe <= '1;
    else     ss_pipe <= {ss_pipe[SYNC_STAGES-2:0], ss_in_n};
  end

  assign fault = spe && mstr && !pdir_q[PIN_SS] && !ss_pipe[SYNC_STAGES-1];
  assign start = data_wr && spe && mstr;
  assign abort = !spe || fault;

  sbm_baud #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .pre  (div_q[PRE_LO +: PRE_W]),
    .expo (div_q[EXP_LO +: EXP_W]),
    .tick (tick)
  );

  sbm_shift #(.W(8)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .abort (abort),
    .tick  (tick),
    .cpol  (cpol),
    .cpha  (cpha),
    .lsbf  (lsbf),
    .miso  (miso),
    .tx    (bus_wdata),
    .busy  (busy),
    .done  (done),
    .sck   (sck),
    .mosi  (mosi),
    .sr    (sr_out)
  );

  // writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      ctl2_q <= '0;
      div_q  <= '0;
      plvl_q <= '0;
      pdir_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(A_CTRL):  ctl_q  <= bus_wdata;
        AW'(A_CTRL2): ctl2_q <= bus_wdata;
        AW'(A_DIV):   div_q  <= bus_wdata & DIV_MASK;
        AW'(A_PLVL):  plvl_q <= bus_wdata;
        AW'(A_PDIR):  pdir_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // flags and their clear sequences
  always_ff @(posedge clk) begin
    if (rst || !spe) begin
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      modf_q  <= 1'b0;
      arm_x_q <= 1'b0;
      arm_m_q <= 1'b0;
    end else begin
      if (done)                     spif_q <= 1'b1;
      else if (data_acc && arm_x_q) spif_q <= 1'b0;

      if (data_wr && busy)          wcol_q <= 1'b1;
      else if (data_acc && arm_x_q) wcol_q <= 1'b0;

      if (status_rd && (spif_q || wcol_q)) arm_x_q <= 1'b1;
      else if (data_acc)                   arm_x_q <= 1'b0;

      if (fault)                  modf_q <= 1'b1;
      else if (ctl_wr && arm_m_q) modf_q <= 1'b0;

      if (status_rd && modf_q) arm_m_q <= 1'b1;
      else if (ctl_wr)         arm_m_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rx_q <= '0;
    else if (done) rx_q <= sr_out;
  end

  always_comb begin
    stat_byte         = '0;
    stat_byte[S_DONE] = spif_q;
    stat_byte[S_COL]  = wcol_q;
    stat_byte[S_FLT]  = modf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        AW'(A_CTRL):  bus_rdata <= ctl_q;
        AW'(A_CTRL2): bus_rdata <= ctl2_q;
        AW'(A_DIV):   bus_rdata <= div_q;
        AW'(A_STAT):  bus_rdata <= stat_byte;
        AW'(A_DATA):  bus_rdata <= rx_q;
        AW'(A_PLVL):  bus_rdata <= plvl_q;
        AW'(A_PDIR):  bus_rdata <= pdir_q;
        default:      bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_done  <= 1'b0;
      irq_fault <= 1'b0;
    end else begin
      irq_done  <= spie && spif_q;
      irq_fault <= spie && modf_q;
    end
  end

  assign ss_oe  = pdir_q[PIN_SS];
  assign ss_n_o = pdir_q[PIN_SS] ? plvl_q[PIN_SS] : 1'b1;
endmodule

// File: rtl/sbm_checks.sv
module sbm_checks (
  input logic clk,
  input logic rst,
  input logic spe,
  input logic cpol,
  input logic spie,
  input logic busy,
  input logic done,
  input logic sck,
  input logic data_wr,
  input logic fault,
  input logic spif,
  input logic wcol,
  input logic modf,
  input logic irq_done,
  input logic irq_fault
);
  // R3: serial clock rests at the polarity level between shifts
  a_r3_sck_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol));

  // R7: a data write during a shift raises the collision flag
  a_r7_collision: assert property (@(posedge clk) disable iff (rst)
    (data_wr && busy && spe) |=> wcol);

  // R8: a fault sets its flag and stops the shifter
  a_r8_fault_abort: assert property (@(posedge clk) disable iff (rst)
    fault |=> (modf && !busy));

  // R9: disabling the block clears every flag
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !spe |=> (!spif && !wcol && !modf));

  // R2: a completed exchange raises the complete flag
  a_r2_done_flag: assert property (@(posedge clk) disable iff (rst)
    (done && spe) |=> spif);

  // R10: interrupt lines follow their flags one clock later
  a_r10_irq_done: assert property (@(posedge clk) disable iff (rst)
    irq_done == $past(spif && spie));

  a_r10_irq_fault: assert property (@(posedge clk) disable iff (rst)
    irq_fault == $past(modf && spie));
endmodule

bind spi_byte_master sbm_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .spe       (spe),
  .cpol      (cpol),
  .spie      (spie),
  .busy      (busy),
  .done      (done),
  .sck       (sck),
  .data_wr   (data_wr),
  .fault     (fault),
  .spif      (spif_q),
  .wcol      (wcol_q),
  .modf      (modf_q),
  .irq_done  (irq_done),
  .irq_fault (irq_fault)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sck, mosi, ss_n_o, ss_oe, irq_done, irq_fault;
  logic       miso = 1'b0;
  logic       ss_in_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  // behavioural slave
  logic       slv_on = 1'b0, slv_cpol = 1'b0, slv_cpha = 1'b0, slv_lsb = 1'b0;
  logic [7:0] slv_tx = '0, slv_rx = '0;
  int         slv_bit = 0;

  always #10 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_in_n(ss_in_n), .ss_n_o(ss_n_o), .ss_oe(ss_oe),
    .irq_done(irq_done), .irq_fault(irq_fault)
  );

  function automatic logic pick(input logic [7:0] b, input int i, input logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  always @(sck) begin
    if (slv_on) begin
      if ((sck != slv_cpol) ^ slv_cpha) begin
        slv_rx = slv_lsb ? {mosi, slv_rx[7:1]} : {slv_rx[6:0], mosi};
      end else if (slv_bit < 8) begin
        miso = pick(slv_tx, slv_bit, slv_lsb);
        slv_bit++;
      end
    end
  end

  function automatic int exp_cycles(input logic [2:0] p, input logic [2:0] e);
    return 16 * ((int'(p) + 1) << e) + 2;
  endfunction

  function automatic logic [7:0] ctl(input logic cp, ph, lb);
    return 8'hD0 | {4'b0, cp, ph, 1'b0, lb};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!irq_done && n < 5000);
  endtask

  task automatic xfer(input logic cp, ph, lb, input logic [2:0] p, e,
                      input logic [7:0] mtx, stx, input bit early);
    logic [7:0] d;
    int n;
    wr(5'h00, ctl(cp, ph, lb));
    wr(5'h04, {1'b0, p, 1'b0, e});
    slv_cpol = cp; slv_cpha = ph; slv_lsb = lb; slv_tx = stx; slv_rx = '0;
    if (!ph) begin miso = pick(stx, 0, lb); slv_bit = 1; end
    else slv_bit = 0;
    slv_on = 1'b1;
    wr(5'h09, mtx);
    wait_irq(n);
    slv_on = 1'b0;
    chk("R4 completion timing", n, exp_cycles(p, e));
    if (early) begin
      rd(5'h09, d); chk("R2 early data read", d, stx);
      rd(5'h05, d); chk("R6 flag kept without status read", d, 8'h80);
    end else begin
      rd(5'h05, d); chk("R5 status after exchange", d, 8'h80);
    end
    rd(5'h09, d); chk("R2 received byte", d, stx);
    chk("R3 byte seen by slave", slv_rx, mtx);
    rd(5'h05, d); chk("R6 flag cleared", d, 8'h00);
    chk("R10 irq_done low after clear", irq_done, 1'b0);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // reset state
    rd(5'h05, d); chk("R1 reset status", d, 8'h00);
    rd(5'h00, d); chk("R1 reset control", d, 8'h00);
    chk("R3 reset sck", sck, 1'b0);
    chk("R11 reset select", ss_n_o, 1'b1);
    chk("R10 reset irq", {irq_done, irq_fault}, 2'b00);

    // register map and pins
    wr(5'h01, 8'h5A); rd(5'h01, d); chk("R1 spare control", d, 8'h5A);
    wr(5'h04, 8'hFF); rd(5'h04, d); chk("R1 divider mask", d, 8'h77);
    rd(5'h02, d); chk("R1 unmapped", d, 8'h00);
    wr(5'h10, 8'h0E); wr(5'h0D, 8'h08);
    rd(5'h10, d); chk("R1 direction readback", d, 8'h0E);
    rd(5'h0D, d); chk("R1 level readback", d, 8'h08);
    chk("R11 select driven high", {ss_oe, ss_n_o}, 2'b11);
    wr(5'h0D, 8'h00);
    chk("R11 select driven low", {ss_oe, ss_n_o}, 2'b10);
    wr(5'h00, 8'h9B); rd(5'h00, d); chk("R1 control readback", d, 8'h9B);

    // directed exchanges in every mode
    xfer(0, 0, 0, 3'd0, 3'd0, 8'hA5, 8'h3C, 0);
    xfer(0, 1, 0, 3'd1, 3'd1, 8'h81, 8'h7E, 0);
    xfer(1, 0, 1, 3'd2, 3'd0, 8'h01, 8'hF0, 0);
    xfer(1, 1, 1, 3'd0, 3'd2, 8'hC6, 8'h19, 1);
    xfer(0, 0, 0, 3'd7, 3'd1, 8'hFF, 8'h00, 0);

    // R7 collision
    wr(5'h00, ctl(0, 0, 0)); wr(5'h04, 8'h10);
    slv_cpol = 0; slv_cpha = 0; slv_lsb = 0; slv_tx = 8'h5A; slv_rx = '0;
    miso = pick(8'h5A, 0, 0); slv_bit = 1; slv_on = 1'b1;
    wr(5'h09, 8'hC3);
    wr(5'h09, 8'h11);
    rd(5'h05, d); chk("R7 collision flag", d, 8'h40);
    wait_irq(n);
    slv_on = 1'b0;
    rd(5'h05, d); chk("R7 both flags", d, 8'hC0);
    rd(5'h09, d); chk("R7 original exchange received", d, 8'h5A);
    chk("R7 dropped byte not sent", slv_rx, 8'hC3);
    rd(5'h05, d); chk("R6 collision cleared", d, 8'h00);

    // R9 disable and master-off
    wr(5'h00, 8'h50); wr(5'h04, 8'h00);
    miso = 1'b1;
    wr(5'h09, 8'h00);
    repeat (30) @(posedge clk);
    rd(5'h09, d); chk("R2 all ones received", d, 8'hFF);
    wr(5'h00, 8'h10);
    rd(5'h05, d); chk("R9 flags cleared by disable", d, 8'h00);
    miso = 1'b0;
    wr(5'h09, 8'h3C);
    repeat (40) @(posedge clk);
    @(negedge clk); chk("R9 sck idle while disabled", sck, 1'b0);
    rd(5'h05, d); chk("R9 no completion while disabled", d, 8'h00);
    rd(5'h09, d); chk("R9 data unchanged while disabled", d, 8'hFF);
    wr(5'h00, 8'h40);
    wr(5'h09, 8'h3C);
    repeat (40) @(posedge clk);
    rd(5'h05, d); chk("R9 no completion with master off", d, 8'h00);
    rd(5'h09, d); chk("R9 data unchanged with master off", d, 8'hFF);

    // R8 mode fault aborting a shift
    wr(5'h10, 8'h00);
    wr(5'h00, ctl(1, 0, 0)); wr(5'h04, 8'h73);
    wr(5'h09, 8'hA5);
    repeat (100) @(posedge clk);
    @(negedge clk); chk("R4 first edge reached", sck, 1'b0);
    ss_in_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8 sck back to idle after abort", sck, 1'b1);
    chk("R10 fault interrupt", irq_fault, 1'b1);
    ss_in_n = 1'b1;
    repeat (1034) @(posedge clk);
    wr(5'h00, ctl(1, 0, 0));
    rd(5'h05, d); chk("R8 fault kept, no completion", d, 8'h10);
    wr(5'h00, ctl(1, 0, 0));
    rd(5'h05, d); chk("R8 fault cleared", d, 8'h00);
    chk("R10 fault interrupt low", irq_fault, 1'b0);

    // random exchanges
    wr(5'h10, 8'h0E);
    for (int i = 0; i < 24; i++) begin
      logic [2:0] p, e;
      logic [7:0] m, s;
      p = 3'($urandom % 4); e = 3'($urandom % 3);
      m = 8'($urandom); s = 8'($urandom);
      xfer(1'($urandom), 1'($urandom), 1'($urandom), p, e, m, s, 0);
    end

    finish_run();
  end
endmodule